// File: doc/BRIEF.md
# SDRAM Bank Open-Page Controller

This block sits between a request splitter and an SDRAM transfer controller. It keeps, for every bank, whether a row is open and which row it is. Each queued request targets one bank and row. The block classifies the request in one of three ways:
- the row is already open (page hit),
- the bank is closed,
- another row is open (page miss).

It then sequences the precharge and activate commands the request needs, spaced by runtime delay settings. Finally it forwards the read or write to the transfer controller.

Every command goes out on a single valid/acknowledge channel with a 2-bit command code, bank and address. Once offered, a command is held unchanged until it is acknowledged. Two kinds of input can hold commands back:
- Permission inputs: a per-bank precharge permission and a global activate permission.
- Refresh request: while it is high, no new activate is offered and no new request is decided, and every bank is marked closed.

A request flagged as the last of a burst stream closes its bank after the transfer.

Top module: `sdr_page_ctrl`

## Requirements
- R1: After reset, `idle` is 1, `out_valid` is 0, `in_ready` is 1 and every bank is closed.
- R2: A request to a closed bank produces an activate (code 2'b01, `out_addr` = row), then a read (2'b10) or write (2'b11) with `out_addr` = column and `out_len` = request length.
- R3: A request whose row equals the open row of its bank produces the read/write directly, with no precharge or activate.
- R4: A request to a bank with a different open row produces precharge (2'b00), then activate of the new row, then read/write.
- R5: After a precharge is acknowledged at clock edge k, the next activate is first offered after edge k+max(`cfg_trp`,1), with `act_ok` high.
- R6: After an activate is acknowledged at edge k, the read/write is first offered after edge k+max(`cfg_trcd`,1).
- R7: A bank's precharge is not offered until `cfg_tras` edges have passed since its activate was acknowledged. With a fast path, it is offered exactly then.
- R8: A request with `in_close` = 1 is followed by a precharge of its bank after the transfer. A later request to the same row then needs an activate.
- R9: A precharge of bank n is newly offered only while `pre_ok[n]` is 1.
- R10: An activate is newly offered only while `act_ok` = 1 and `refresh_req` = 0. While `refresh_req` is high, no queued request is decided and all banks become closed.
- R11: The queue accepts a request (`in_ready` = 1) only while it holds at most `cfg_depth` entries, which gives a cap of `cfg_depth`+1 entries. Requests are served in arrival order.
- R12: `idle` is 1 exactly when the queue is empty and no command sequence is in progress. `idle` implies `out_valid` = 0.
- R13: While `out_valid` is 1 and `out_ack` is 0, the next cycle keeps `out_valid`, `out_cmd`, `out_bank` and `out_addr` unchanged, even if a permission input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | QD_W | Queue fill limit (accepts while fill <= value) |
| cfg_tras | input | TIME_W | Minimum activate-to-precharge cycles |
| cfg_trp | input | TIME_W | Precharge-to-activate cycles |
| cfg_trcd | input | TIME_W | Activate-to-read/write cycles |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_bank | input | BANK_W | Target bank |
| in_row | input | ROW_W | Target row |
| in_col | input | COL_W | Start column |
| in_len | input | LEN_W | Transfer length |
| in_write | input | 1 | 1 = write, 0 = read |
| in_close | input | 1 | Close bank after this transfer |
| out_valid | output | 1 | Command offered |
| out_ack | input | 1 | Command taken by transfer controller |
| out_cmd | output | 2 | 00 precharge, 01 activate, 10 read, 11 write |
| out_bank | output | BANK_W | Command bank |
| out_addr | output | ADDR_W | Row (activate) or column (read/write) |
| out_len | output | LEN_W | Transfer length |
| pre_ok | input | NUM_BANKS | Per-bank precharge permission |
| act_ok | input | 1 | Activate permission |
| refresh_req | input | 1 | Refresh pending |
| idle | output | 1 | Nothing queued or in progress |

## Verification
Two things can coincide in one cycle: a permission input dropping and a command that has already been offered but not yet acknowledged. The bench first waits for a precharge to be offered and lets one clock edge pass without an acknowledge. It then clears that bank's `pre_ok` and judges at the ports that the offer stays valid and unchanged until it is taken. The other coincidence is a refresh request arriving while a request waits in the queue. The bench checks that nothing is offered during the refresh. It also checks that the request, although it hits the previously open row, is then served with a fresh activate.

// File: rtl/sdr_page_pkg.sv
package sdr_page_pkg;

    typedef enum logic [1:0] {
        CMD_PRE = 2'b00,
        CMD_ACT = 2'b01,
        CMD_RD  = 2'b10,
        CMD_WR  = 2'b11
    } pg_cmd_e;

    typedef enum logic [2:0] {
        ST_DECIDE,
        ST_PRE,
        ST_WAIT_RP,
        ST_ACT,
        ST_WAIT_RCD,
        ST_XFER
    } pg_state_e;

endpackage

// File: rtl/pg_req_queue.sv
module pg_req_queue #(
    parameter int ENTRY_W = 8,
    parameter int QD_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [QD_W-1:0]    cfg_depth,
    input  logic               push_valid,
    input  logic [ENTRY_W-1:0] push_data,
    output logic               push_ready,
    input  logic               pop,
    output logic               head_valid,
    output logic [ENTRY_W-1:0] head_data
);
    localparam int CAP = 1 << QD_W;

    typedef struct packed {
        logic [QD_W-1:0] wp;
        logic [QD_W-1:0] rp;
        logic [QD_W:0]   cnt;
    } qptr_t;

    qptr_t p_d, p_q;
    logic [ENTRY_W-1:0] mem_d [CAP];
    logic [ENTRY_W-1:0] mem_q [CAP];
    logic do_push, do_pop;

    always_comb begin
        p_d        = p_q;
        mem_d      = mem_q;
        push_ready = (p_q.cnt <= {1'b0, cfg_depth});
        head_valid = (p_q.cnt != '0);
        head_data  = mem_q[p_q.rp];
        do_push    = push_valid && push_ready;
        do_pop     = pop && head_valid;
        if (do_push) begin
            mem_d[p_q.wp] = push_data;
            p_d.wp        = p_q.wp + 1'b1;
        end
        if (do_pop) begin
            p_d.rp = p_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/pg_bank_table.sv
module pg_bank_table #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 12,
    parameter int TIME_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [TIME_W-1:0]          cfg_tras,
    input  logic                       act_fire,
    input  logic                       pre_fire,
    input  logic                       flush,
    input  logic [BANK_W-1:0]          sel_bank,
    input  logic [ROW_W-1:0]           act_row,
    output logic [NUM_BANKS-1:0]       open_vec,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows,
    output logic [NUM_BANKS-1:0]       ras_done
);

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        typedef struct packed {
            logic              open;
            logic [ROW_W-1:0]  row;
            logic [TIME_W-1:0] ras;
        } bank_t;

        bank_t b_d, b_q;
        logic  here;

        always_comb begin
            b_d  = b_q;
            here = (sel_bank == BANK_W'(i));
            if (b_q.ras != '0) b_d.ras = b_q.ras - 1'b1;
            if (act_fire && here) begin
                b_d.open = 1'b1;
                b_d.row  = act_row;
                b_d.ras  = cfg_tras;
            end
            if (pre_fire && here) b_d.open = 1'b0;
            if (flush)            b_d.open = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) b_q <= '0;
            else        b_q <= b_d;
        end

        assign open_vec[i]                  = b_q.open;
        assign open_rows[i*ROW_W +: ROW_W]  = b_q.row;
        assign ras_done[i]                  = (b_q.ras == '0);
    end

endmodule

// File: rtl/pg_sequencer.sv
module pg_sequencer
    import sdr_page_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 10,
    parameter int LEN_W     = 9,
    parameter int TIME_W    = 4,
    parameter int ADDR_W    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [TIME_W-1:0]          cfg_trp,
    input  logic [TIME_W-1:0]          cfg_trcd,
    input  logic                       head_valid,
    input  logic [BANK_W-1:0]          head_bank,
    input  logic [ROW_W-1:0]           head_row,
    input  logic [COL_W-1:0]           head_col,
    input  logic [LEN_W-1:0]           head_len,
    input  logic                       head_write,
    input  logic                       head_close,
    output logic                       pop,
    input  logic [NUM_BANKS-1:0]       open_vec,
    input  logic [NUM_BANKS*ROW_W-1:0] open_rows,
    input  logic [NUM_BANKS-1:0]       ras_done,
    input  logic [NUM_BANKS-1:0]       pre_ok,
    input  logic                       act_ok,
    input  logic                       refresh_req,
    output logic                       act_fire,
    output logic                       pre_fire,
    output logic                       flush,
    output logic [BANK_W-1:0]          fire_bank,
    output logic [ROW_W-1:0]           fire_row,
    output logic                       out_valid,
    input  logic                       out_ack,
    output logic [1:0]                 out_cmd,
    output logic [BANK_W-1:0]          out_bank,
    output logic [ADDR_W-1:0]          out_addr,
    output logic [LEN_W-1:0]           out_len,
    output logic                       busy
);

    typedef struct packed {
        pg_state_e         st;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [LEN_W-1:0]  len;
        logic              write;
        logic              close;
        logic              closing;
        logic              issued;
        logic [TIME_W-1:0] cnt;
    } seq_t;

    seq_t d, q;
    logic hit;
    logic fire;

    always_comb begin
        d         = q;
        pop       = 1'b0;
        act_fire  = 1'b0;
        pre_fire  = 1'b0;
        flush     = 1'b0;
        out_valid = 1'b0;
        out_cmd   = CMD_PRE;
        out_addr  = '0;
        hit       = open_vec[head_bank] &&
                    (open_rows[head_bank*ROW_W +: ROW_W] == head_row);
        fire      = 1'b0;

        case (q.st)
            ST_DECIDE: begin
                if (refresh_req) begin
                    flush = 1'b1;
                end else if (head_valid) begin
                    pop       = 1'b1;
                    d.bank    = head_bank;
                    d.row     = head_row;
                    d.col     = head_col;
                    d.len     = head_len;
                    d.write   = head_write;
                    d.close   = head_close;
                    d.closing = 1'b0;
                    d.issued  = 1'b0;
                    if (!open_vec[head_bank]) d.st = ST_ACT;
                    else if (hit)             d.st = ST_XFER;
                    else                      d.st = ST_PRE;
                end
            end
            ST_PRE: begin
                out_cmd   = CMD_PRE;
                out_valid = q.issued || (pre_ok[q.bank] && ras_done[q.bank]);
                fire      = out_valid && out_ack;
                d.issued  = out_valid && !out_ack;
                if (fire) begin
                    pre_fire = 1'b1;
                    d.cnt    = cfg_trp;
                    d.st     = ST_WAIT_RP;
                end
            end
            ST_WAIT_RP: begin
                if (q.cnt <= TIME_W'(1)) begin
                    d.st      = q.closing ? ST_DECIDE : ST_ACT;
                    d.closing = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_ACT: begin
                out_cmd   = CMD_ACT;
                out_addr  = ADDR_W'(q.row);
                out_valid = q.issued || (act_ok && !refresh_req);
                fire      = out_valid && out_ack;
                d.issued  = out_valid && !out_ack;
                if (fire) begin
                    act_fire = 1'b1;
                    d.cnt    = cfg_trcd;
                    d.st     = ST_WAIT_RCD;
                end
            end
            ST_WAIT_RCD: begin
                if (q.cnt <= TIME_W'(1)) d.st  = ST_XFER;
                else                     d.cnt = q.cnt - 1'b1;
            end
            ST_XFER: begin
                out_cmd   = q.write ? CMD_WR : CMD_RD;
                out_addr  = ADDR_W'(q.col);
                out_valid = 1'b1;
                fire      = out_ack;
                if (fire) begin
                    d.issued = 1'b0;
                    if (q.close) begin
                        d.closing = 1'b1;
                        d.st      = ST_PRE;
                    end else begin
                        d.st = ST_DECIDE;
                    end
                end
            end
            default: d.st = ST_DECIDE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fire_bank = q.bank;
    assign fire_row  = q.row;
    assign out_bank  = q.bank;
    assign out_len   = q.len;
    assign busy      = (q.st != ST_DECIDE);

endmodule

// File: rtl/sdr_page_ctrl.sv
module sdr_page_ctrl #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 10,
    parameter int LEN_W     = 9,
    parameter int TIME_W    = 4,
    parameter int QD_W      = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [QD_W-1:0]          cfg_depth,
    input  logic [TIME_W-1:0]        cfg_tras,
    input  logic [TIME_W-1:0]        cfg_trp,
    input  logic [TIME_W-1:0]        cfg_trcd,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [$clog2(NUM_BANKS)-1:0] in_bank,
    input  logic [ROW_W-1:0]         in_row,
    input  logic [COL_W-1:0]         in_col,
    input  logic [LEN_W-1:0]         in_len,
    input  logic                     in_write,
    input  logic                     in_close,
    output logic                     out_valid,
    input  logic                     out_ack,
    output logic [1:0]               out_cmd,
    output logic [$clog2(NUM_BANKS)-1:0] out_bank,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] out_addr,
    output logic [LEN_W-1:0]         out_len,
    input  logic [NUM_BANKS-1:0]     pre_ok,
    input  logic                     act_ok,
    input  logic                     refresh_req,
    output logic                     idle
);
    localparam int BANK_W  = $clog2(NUM_BANKS);
    localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int ENTRY_W = BANK_W + ROW_W + COL_W + LEN_W + 2;

    logic [ENTRY_W-1:0]         push_data, head_data;
    logic                       head_valid, pop;
    logic [BANK_W-1:0]          h_bank;
    logic [ROW_W-1:0]           h_row;
    logic [COL_W-1:0]           h_col;
    logic [LEN_W-1:0]           h_len;
    logic                       h_write, h_close;
    logic [NUM_BANKS-1:0]       open_vec, ras_done;
    logic [NUM_BANKS*ROW_W-1:0] open_rows;
    logic                       act_fire, pre_fire, flush, seq_busy;
    logic [BANK_W-1:0]          fire_bank;
    logic [ROW_W-1:0]           fire_row;

    assign push_data = {in_bank, in_row, in_col, in_len, in_write, in_close};
    assign {h_bank, h_row, h_col, h_len, h_write, h_close} = head_data;

    pg_req_queue #(.ENTRY_W(ENTRY_W), .QD_W(QD_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_depth  (cfg_depth),
        .push_valid (in_valid),
        .push_data  (push_data),
        .push_ready (in_ready),
        .pop        (pop),
        .head_valid (head_valid),
        .head_data  (head_data)
    );

    pg_bank_table #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
                    .TIME_W(TIME_W)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_tras  (cfg_tras),
        .act_fire  (act_fire),
        .pre_fire  (pre_fire),
        .flush     (flush),
        .sel_bank  (fire_bank),
        .act_row   (fire_row),
        .open_vec  (open_vec),
        .open_rows (open_rows),
        .ras_done  (ras_done)
    );

    pg_sequencer #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
                   .COL_W(COL_W), .LEN_W(LEN_W), .TIME_W(TIME_W),
                   .ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_trp     (cfg_trp),
        .cfg_trcd    (cfg_trcd),
        .head_valid  (head_valid),
        .head_bank   (h_bank),
        .head_row    (h_row),
        .head_col    (h_col),
        .head_len    (h_len),
        .head_write  (h_write),
        .head_close  (h_close),
        .pop         (pop),
        .open_vec    (open_vec),
        .open_rows   (open_rows),
        .ras_done    (ras_done),
        .pre_ok      (pre_ok),
        .act_ok      (act_ok),
        .refresh_req (refresh_req),
        .act_fire    (act_fire),
        .pre_fire    (pre_fire),
        .flush       (flush),
        .fire_bank   (fire_bank),
        .fire_row    (fire_row),
        .out_valid   (out_valid),
        .out_ack     (out_ack),
        .out_cmd     (out_cmd),
        .out_bank    (out_bank),
        .out_addr    (out_addr),
        .out_len     (out_len),
        .busy        (seq_busy)
    );

    assign idle = !seq_busy && !head_valid;

endmodule

// File: rtl/pg_page_ctrl_chk.sv
module pg_page_ctrl_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 out_valid,
    input logic                 out_ack,
    input logic [1:0]           out_cmd,
    input logic [BANK_W-1:0]    out_bank,
    input logic [ADDR_W-1:0]    out_addr,
    input logic [NUM_BANKS-1:0] pre_ok,
    input logic                 act_ok,
    input logic                 refresh_req,
    input logic                 idle
);

    // R13: an unacknowledged offer is held unchanged
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ack) |=>
        (out_valid && $stable(out_cmd) && $stable(out_bank) && $stable(out_addr)));

    // R9: a fresh precharge offer needs the bank's permission
    a_r9_pre_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (!$past(out_valid) || $past(out_ack)) && out_cmd == 2'b00)
        |-> pre_ok[out_bank]);

    // R10: a fresh activate offer needs permission and no refresh
    a_r10_act_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (!$past(out_valid) || $past(out_ack)) && out_cmd == 2'b01)
        |-> (act_ok && !refresh_req));

    // R5: nothing is offered in the cycle after a precharge is taken
    a_r5_rp_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ack && out_cmd == 2'b00) |=> !out_valid);

    // R6: nothing is offered in the cycle after an activate is taken
    a_r6_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ack && out_cmd == 2'b01) |=> !out_valid);

    // R12: idle never coexists with an offer
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !out_valid);

endmodule

bind sdr_page_ctrl pg_page_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid   (out_valid),
    .out_ack     (out_ack),
    .out_cmd     (out_cmd),
    .out_bank    (out_bank),
    .out_addr    (out_addr),
    .pre_ok      (pre_ok),
    .act_ok      (act_ok),
    .refresh_req (refresh_req),
    .idle        (idle)
);

// File: tb/tb_sdr_page_ctrl.sv
module tb_sdr_page_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_depth = 2'd3;
    logic [3:0]  cfg_tras = 4'd0, cfg_trp = 4'd1, cfg_trcd = 4'd1;
    logic        in_valid = 1'b0, in_write = 1'b0, in_close = 1'b0;
    logic        in_ready;
    logic [1:0]  in_bank = '0;
    logic [11:0] in_row = '0;
    logic [9:0]  in_col = '0;
    logic [8:0]  in_len = '0;
    logic        out_valid, out_ack = 1'b0;
    logic [1:0]  out_cmd, out_bank;
    logic [11:0] out_addr;
    logic [8:0]  out_len;
    logic [3:0]  pre_ok = 4'hF;
    logic        act_ok = 1'b1, refresh_req = 1'b0;
    logic        idle;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    sdr_page_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_tras(cfg_tras),
        .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .in_valid(in_valid),
        .in_ready(in_ready), .in_bank(in_bank), .in_row(in_row),
        .in_col(in_col), .in_len(in_len), .in_write(in_write),
        .in_close(in_close), .out_valid(out_valid), .out_ack(out_ack),
        .out_cmd(out_cmd), .out_bank(out_bank), .out_addr(out_addr),
        .out_len(out_len), .pre_ok(pre_ok), .act_ok(act_ok),
        .refresh_req(refresh_req), .idle(idle)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int mx1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int b, input int row, input int col,
                        input int wr, input int cl, input int len);
        while (!in_ready) @(negedge clk);
        in_bank = b[1:0]; in_row = row[11:0]; in_col = col[9:0];
        in_write = wr[0]; in_close = cl[0]; in_len = len[8:0];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic take(input int cmd, input int b, input int addr, input int len,
                        input string tag, output int seen, output int acked);
        int n = 0;
        while (!out_valid && n < 300) begin
            @(negedge clk);
            n++;
        end
        seen = cyc;
        chk({tag, " valid"}, int'(out_valid), 1);
        chk({tag, " cmd"}, int'(out_cmd), cmd);
        chk({tag, " bank"}, int'(out_bank), b);
        if (addr >= 0) chk({tag, " addr"}, int'(out_addr), addr);
        if (len >= 0)  chk({tag, " len"}, int'(out_len), len);
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
        acked = cyc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s, a, s2, a2, a_act;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R12 idle
        chk("R1 idle", int'(idle), 1);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 in_ready", int'(in_ready), 1);

        // R2 closed bank: activate then read
        push(0, 'h10, 5, 0, 0, 4);
        chk("R12 busy after push", int'(idle), 0);
        take(1, 0, 'h10, -1, "R1 R2 act", s, a);
        take(2, 0, 5, 4, "R2 read", s, a);
        chk("R12 idle after read", int'(idle), 1);

        // R3 hit: write goes out directly
        push(0, 'h10, 7, 1, 0, 2);
        take(3, 0, 7, 2, "R3 hit write", s, a);

        // R4 R5 R6 sweep over all precharge/activate delays
        for (int rp = 0; rp < 16; rp++) begin
            for (int rcd = 0; rcd < 16; rcd++) begin
                cfg_trp = rp[3:0];
                cfg_trcd = rcd[3:0];
                push(0, 'h100 + rp * 16 + rcd, rcd, rp % 2, 0, rcd + 1);
                take(0, 0, -1, -1, "R4 miss pre", s, a);
                take(1, 0, 'h100 + rp * 16 + rcd, -1, "R4 act", s2, a2);
                chk("R5 trp latency", s2 - a, mx1(rp));
                take(2 + (rp % 2), 0, rcd, rcd + 1, "R4 rw", s, a);
                chk("R6 trcd latency", s - a2, mx1(rcd));
            end
        end
        cfg_trp = 4'd1;
        cfg_trcd = 4'd1;

        // R7 tRAS and R8 close-after-transfer
        cfg_tras = 4'd15;
        push(1, 5, 1, 0, 1, 1);
        take(1, 1, 5, -1, "R8 act", s, a_act);
        take(2, 1, 1, 1, "R8 read", s, a);
        take(0, 1, -1, -1, "R8 close pre", s, a);
        chk("R7 tras latency", s - a_act, 15);
        cfg_tras = 4'd0;
        push(1, 5, 2, 0, 0, 1);
        take(1, 1, 5, -1, "R8 reopen act", s, a);
        take(2, 1, 2, 1, "R8 read", s, a);

        // R9 precharge permission and R13 hold
        push(2, 1, 3, 0, 0, 1);
        take(1, 2, 1, -1, "R9 act", s, a);
        take(2, 2, 3, 1, "R9 read", s, a);
        pre_ok = 4'b1011;
        push(2, 2, 4, 0, 0, 1);
        repeat (20) @(negedge clk);
        chk("R9 no pre while blocked", int'(out_valid), 0);
        pre_ok = 4'hF;
        while (!out_valid) @(negedge clk);
        @(negedge clk);
        pre_ok = 4'b1011;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R13 hold valid", int'(out_valid), 1);
            chk("R13 hold cmd", int'(out_cmd), 0);
            chk("R13 hold bank", int'(out_bank), 2);
        end
        take(0, 2, -1, -1, "R9 pre", s, a);
        pre_ok = 4'hF;
        take(1, 2, 2, -1, "R9 act new row", s, a);
        take(2, 2, 4, 1, "R9 read", s, a);

        // R10 activate permission and refresh
        act_ok = 1'b0;
        push(3, 7, 0, 0, 0, 1);
        repeat (15) @(negedge clk);
        chk("R10 no act while blocked", int'(out_valid), 0);
        act_ok = 1'b1;
        take(1, 3, 7, -1, "R10 act", s, a);
        take(2, 3, 0, 1, "R10 read", s, a);
        refresh_req = 1'b1;
        push(3, 7, 1, 0, 0, 1);
        repeat (10) @(negedge clk);
        chk("R10 quiet during refresh", int'(out_valid), 0);
        refresh_req = 1'b0;
        take(1, 3, 7, -1, "R10 act after refresh", s, a);
        take(2, 3, 1, 1, "R10 read", s, a);

        // R11 depth limit and arrival order
        refresh_req = 1'b1;
        repeat (2) @(negedge clk);
        refresh_req = 1'b0;
        act_ok = 1'b0;
        cfg_depth = 2'd0;
        push(0, 'h21, 1, 0, 0, 1);
        repeat (2) @(negedge clk);
        push(1, 'h22, 2, 0, 0, 1);
        chk("R11 full at depth 0", int'(in_ready), 0);
        cfg_depth = 2'd3;
        #1;
        chk("R11 ready at depth 3", int'(in_ready), 1);
        push(2, 'h23, 3, 0, 0, 1);
        push(3, 'h24, 4, 0, 0, 1);
        push(1, 'h25, 5, 0, 0, 1);
        chk("R11 full at capacity", int'(in_ready), 0);
        act_ok = 1'b1;
        take(1, 0, 'h21, -1, "R11 order act0", s, a);
        take(2, 0, 1, 1, "R11 order rd0", s, a);
        take(1, 1, 'h22, -1, "R11 order act1", s, a);
        take(2, 1, 2, 1, "R11 order rd1", s, a);
        take(1, 2, 'h23, -1, "R11 order act2", s, a);
        take(2, 2, 3, 1, "R11 order rd2", s, a);
        take(1, 3, 'h24, -1, "R11 order act3", s, a);
        take(2, 3, 4, 1, "R11 order rd3", s, a);
        take(0, 1, -1, -1, "R11 order pre1", s, a);
        take(1, 1, 'h25, -1, "R11 order act1b", s, a);
        take(2, 1, 5, 1, "R11 order rd1b", s, a);
        chk("R12 idle at end", int'(idle), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule